// File: doc/BRIEF.md
# Thread-Group Lane Sequencer

This block executes one data-parallel instruction for a group of threads on a datapath that is narrower than the group. With the default parameters a group holds 32 threads and the datapath has 16 lanes. The block therefore runs the group in consecutive passes. In pass 0 the lanes serve threads 0 to 15, and in pass 1 they serve threads 16 to 31. Each lane owns a private register bank. That bank holds, for every group and every pass, one 64-entry context of 32-bit registers. A thread's operands are always read from its own lane's bank, and its result is always written back there.

A start strobe carries an instruction into the block. The instruction has an opcode, a destination register, two source registers, a group number and a 32-bit per-thread activity mask. The block latches the instruction and issues the passes on back-to-back cycles. In each pass it shows the lane enables, the pass index, the bank-local read and write addresses and the per-lane results. A one-cycle done pulse follows the last pass. A new start is accepted in the same cycle as that pulse.

Top module: `warp_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block shows no lane enables, no done pulse and pass index 0 until a start is accepted. A reset in the middle of an instruction abandons it, and no done pulse follows.
- R2: A start accepted at a clock edge is followed by exactly PASSES busy cycles with pass index 0, 1, ... in order. Done is then high for exactly one cycle, and low in every other cycle.
- R3: In pass p, lane enable l equals mask bit p*LANES+l. When no instruction is in flight, all lane enables are 0.
- R4: In pass p, the read and write addresses are (group*PASSES + p)*NREGS + register number, for source a, source b and the destination respectively.
- R5: Opcode 0 adds, 1 subtracts (a-b, modulo 2^32), 2 ANDs, 3 ORs, 4 XORs, and 5 shifts a left by the low 5 bits of b.
- R6: Opcode 6 writes the immediate {src_a, src_b} (src_a in the upper 6 bits), zero-extended. Opcode 7 writes the global thread number group*THREADS + p*LANES + l.
- R7: A start raised while an instruction is in flight is ignored. The running instruction keeps its addresses and its pass count, and the ignored instruction writes nothing.
- R8: A start raised in the done cycle is accepted, and its pass 0 follows in the very next cycle.
- R9: Opcodes 8 to 15 enable no lane and change no register, but still take PASSES cycles and end with done.
- R10: A thread whose mask bit is 0 keeps its old destination value.
- R11: Registers of one group are unaffected by instructions that name another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept an instruction when idle |
| op_i | input | 4 | Opcode |
| dst_i | input | RW (6) | Destination register number |
| src_a_i | input | RW (6) | First source register number |
| src_b_i | input | RW (6) | Second source register number |
| grp_i | input | GW (1) | Thread-group number |
| mask_i | input | THREADS (32) | Per-thread activity mask |
| lane_en_o | output | LANES (16) | Per-lane write enable of the current pass |
| pass_o | output | PW (1) | Current pass index |
| rd_addr_a_o | output | AW (8) | Bank-local address of source a |
| rd_addr_b_o | output | AW (8) | Bank-local address of source b |
| wr_addr_o | output | AW (8) | Bank-local address of the destination |
| wb_data_o | output | LANES*XLEN (512) | Per-lane results of the current pass |
| done_o | output | 1 | One-cycle pulse after the last pass |

## Verification
The bench builds the block with its default parameters: 16 lanes, 32 threads, 64 registers and two groups. Every instruction therefore spans two passes, and the group bit appears in the address. With these values the bench can reach both halves of the mask and the stride of one register context between passes. It can also check that the two groups are isolated, and it can read back results that depend on each thread's lane and pass. The shadow model holds every register of both groups, so any unmasked write, any misrouted write and any missing write shows up in a later read.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;

  localparam int XLEN = 32;
  localparam int OPW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_MOVI = 4'd6,
    OP_TID  = 4'd7
  } lane_op_e;

  // Upper half of the opcode space is reserved: such codes write nothing.
  function automatic logic op_writes(input logic [OPW-1:0] op);
    return !op[OPW-1];
  endfunction

  function automatic logic [XLEN-1:0] lane_alu(
    input logic [OPW-1:0]  op,
    input logic [XLEN-1:0] a,
    input logic [XLEN-1:0] b,
    input logic [XLEN-1:0] imm,
    input logic [XLEN-1:0] tid
  );
    logic [XLEN-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SHL:  r = a << b[4:0];
      OP_MOVI: r = imm;
      OP_TID:  r = tid;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/warp_seq_ctrl.sv
module warp_seq_ctrl #(
  parameter  int LANES   = 16,
  parameter  int THREADS = 32,
  parameter  int NREGS   = 64,
  parameter  int NGROUPS = 2,
  localparam int PASSES  = THREADS / LANES,
  localparam int PW      = (PASSES > 1) ? $clog2(PASSES) : 1,
  localparam int RW      = $clog2(NREGS),
  localparam int GW      = $clog2(NGROUPS),
  localparam int AW      = GW + PW + RW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [warp_seq_pkg::OPW-1:0]  op_i,
  input  logic [RW-1:0]                 dst_i,
  input  logic [RW-1:0]                 src_a_i,
  input  logic [RW-1:0]                 src_b_i,
  input  logic [GW-1:0]                 grp_i,
  input  logic [THREADS-1:0]            mask_i,
  output logic                          busy_o,
  output logic [PW-1:0]                 pass_o,
  output logic [GW-1:0]                 grp_o,
  output logic [warp_seq_pkg::OPW-1:0]  op_o,
  output logic [2*RW-1:0]               imm_o,
  output logic [LANES-1:0]              lane_en_o,
  output logic [AW-1:0]                 rd_a_o,
  output logic [AW-1:0]                 rd_b_o,
  output logic [AW-1:0]                 wr_o,
  output logic                          done_o
);
  import warp_seq_pkg::*;

  logic                busy_q, busy_d;
  logic [PW-1:0]       pass_q, pass_d;
  logic                done_q, done_d;
  logic                last_pass, accept;

  logic [OPW-1:0]      op_q;
  logic [RW-1:0]       dst_q, sa_q, sb_q;
  logic [GW-1:0]       grp_q;
  logic [THREADS-1:0]  mask_q;

  assign last_pass = (pass_q == PW'(PASSES - 1));
  assign accept    = start_i && !busy_q;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    pass_d = pass_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (last_pass) begin
        busy_d = 1'b0;
        pass_d = '0;
        done_d = 1'b1;
      end else begin
        pass_d = pass_q + PW'(1);
      end
    end else if (accept) begin
      busy_d = 1'b1;
      pass_d = '0;
    end
  end

  // Control state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pass_q <= pass_d;
      done_q <= done_d;
    end
  end

  // Instruction latch, clock-enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= op_i;
      dst_q  <= dst_i;
      sa_q   <= src_a_i;
      sb_q   <= src_b_i;
      grp_q  <= grp_i;
      mask_q <= mask_i;
    end
  end

  assign busy_o    = busy_q;
  assign pass_o    = pass_q;
  assign grp_o     = grp_q;
  assign op_o      = op_q;
  assign imm_o     = {sa_q, sb_q};
  assign done_o    = done_q;
  assign lane_en_o = (busy_q && op_writes(op_q)) ? mask_q[pass_q*LANES +: LANES] : '0;

  // Bank-local row = group*PASSES + pass; powers of two make this a concatenation.
  assign rd_a_o = {grp_q, pass_q, sa_q};
  assign rd_b_o = {grp_q, pass_q, sb_q};
  assign wr_o   = {grp_q, pass_q, dst_q};

endmodule

// File: rtl/warp_seq_lane.sv
module warp_seq_lane #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic                               clk,
  input  logic                               we_i,
  input  logic [AW-1:0]                      wr_addr_i,
  input  logic [AW-1:0]                      rd_a_i,
  input  logic [AW-1:0]                      rd_b_i,
  input  logic [warp_seq_pkg::OPW-1:0]       op_i,
  input  logic [warp_seq_pkg::XLEN-1:0]      imm_i,
  input  logic [warp_seq_pkg::XLEN-1:0]      tid_i,
  output logic [warp_seq_pkg::XLEN-1:0]      res_o
);
  import warp_seq_pkg::*;

  logic [XLEN-1:0] bank_q [DEPTH];
  logic [XLEN-1:0] opa, opb;

  // Asynchronous read ports so a pass completes in one cycle
  assign opa   = bank_q[rd_a_i];
  assign opb   = bank_q[rd_b_i];
  assign res_o = lane_alu(op_i, opa, opb, imm_i, tid_i);

  always_ff @(posedge clk) begin
    if (we_i) begin
      bank_q[wr_addr_i] <= res_o;
    end
  end

endmodule

// File: rtl/warp_seq.sv
module warp_seq #(
  parameter  int LANES   = 16,
  parameter  int THREADS = 32,
  parameter  int NREGS   = 64,
  parameter  int NGROUPS = 2,
  localparam int XLEN    = warp_seq_pkg::XLEN,
  localparam int PASSES  = THREADS / LANES,
  localparam int PW      = (PASSES > 1) ? $clog2(PASSES) : 1,
  localparam int RW      = $clog2(NREGS),
  localparam int GW      = $clog2(NGROUPS),
  localparam int LW      = $clog2(LANES),
  localparam int AW      = GW + PW + RW,
  localparam int DEPTH   = NGROUPS * PASSES * NREGS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [3:0]              op_i,
  input  logic [RW-1:0]           dst_i,
  input  logic [RW-1:0]           src_a_i,
  input  logic [RW-1:0]           src_b_i,
  input  logic [GW-1:0]           grp_i,
  input  logic [THREADS-1:0]      mask_i,
  output logic [LANES-1:0]        lane_en_o,
  output logic [PW-1:0]           pass_o,
  output logic [AW-1:0]           rd_addr_a_o,
  output logic [AW-1:0]           rd_addr_b_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [LANES*XLEN-1:0]   wb_data_o,
  output logic                    done_o
);
  import warp_seq_pkg::*;

  logic             busy;
  logic [PW-1:0]    pass;
  logic [GW-1:0]    grp;
  logic [OPW-1:0]   op;
  logic [2*RW-1:0]  imm;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]    rd_a, rd_b, wr;
  logic             done;
  logic [XLEN-1:0]  imm_ext;

  warp_seq_ctrl #(
    .LANES(LANES), .THREADS(THREADS), .NREGS(NREGS), .NGROUPS(NGROUPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .dst_i    (dst_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .grp_i    (grp_i),
    .mask_i   (mask_i),
    .busy_o   (busy),
    .pass_o   (pass),
    .grp_o    (grp),
    .op_o     (op),
    .imm_o    (imm),
    .lane_en_o(lane_en),
    .rd_a_o   (rd_a),
    .rd_b_o   (rd_b),
    .wr_o     (wr),
    .done_o   (done)
  );

  assign imm_ext = XLEN'(imm);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [XLEN-1:0] tid;
    logic [XLEN-1:0] res;

    // Global thread number = group*THREADS + pass*LANES + lane
    assign tid = XLEN'({grp, pass, LW'(l)});

    warp_seq_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk      (clk),
      .we_i     (lane_en[l]),
      .wr_addr_i(wr),
      .rd_a_i   (rd_a),
      .rd_b_i   (rd_b),
      .op_i     (op),
      .imm_i    (imm_ext),
      .tid_i    (tid),
      .res_o    (res)
    );

    assign wb_data_o[l*XLEN +: XLEN] = res;
  end

  assign lane_en_o   = lane_en;
  assign pass_o      = pass;
  assign rd_addr_a_o = rd_a;
  assign rd_addr_b_o = rd_b;
  assign wr_addr_o   = wr;
  assign done_o      = done;

endmodule

// File: rtl/warp_seq_chk.sv
module warp_seq_chk #(
  parameter int LANES  = 16,
  parameter int PASSES = 2,
  parameter int NREGS  = 64,
  parameter int PW     = 1,
  parameter int AW     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [PW-1:0]    pass,
  input logic [LANES-1:0] lane_en,
  input logic [AW-1:0]    rd_a,
  input logic [AW-1:0]    wr,
  input logic             done
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(pass) == PW'(PASSES - 1)));

  assert_pass_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pass != PW'(PASSES - 1)) |=> (busy && pass == $past(pass) + PW'(1)));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_en == '0));

  assert_src_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pass != '0) |-> (rd_a == $past(rd_a) + AW'(NREGS)));

  assert_dst_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pass != '0) |-> (wr == $past(wr) + AW'(NREGS)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pass == PW'(PASSES - 1)) |=> !busy);

endmodule

bind warp_seq warp_seq_chk #(
  .LANES(LANES), .PASSES(PASSES), .NREGS(NREGS), .PW(PW), .AW(AW)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .pass   (pass),
  .lane_en(lane_en),
  .rd_a   (rd_a),
  .wr     (wr),
  .done   (done)
);

// File: tb/warp_seq_bench.sv
module warp_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES   = 16;
  localparam int THREADS = 32;
  localparam int NREGS   = 64;
  localparam int NGROUPS = 2;
  localparam int PASSES  = THREADS / LANES;
  localparam int XLEN    = 32;
  localparam int AW      = 8;
  localparam int NVEC    = 11;

  typedef struct packed {
    logic [3:0]  op;
    logic [5:0]  dst;
    logic [5:0]  sa;
    logic [5:0]  sb;
    logic        grp;
    logic [31:0] mask;
  } vec_t;

  // Stimulus table; expected results come from the shadow register model.
  localparam vec_t VECS [NVEC] = '{
    '{4'd7, 6'd1,  6'd0,  6'd0,  1'b0, 32'hFFFF_FFFF},  // TID  r1
    '{4'd6, 6'd2,  6'd3,  6'd5,  1'b0, 32'hFFFF_FFFF},  // MOVI r2 = 197
    '{4'd0, 6'd3,  6'd1,  6'd2,  1'b0, 32'hFFFF_FFFF},  // ADD
    '{4'd1, 6'd4,  6'd1,  6'd2,  1'b0, 32'hFFFF_FFFF},  // SUB (wraps)
    '{4'd4, 6'd5,  6'd3,  6'd1,  1'b0, 32'h8001_7FFE},  // XOR partial mask
    '{4'd2, 6'd6,  6'd3,  6'd2,  1'b0, 32'hFFFF_FFFF},  // AND
    '{4'd3, 6'd7,  6'd4,  6'd1,  1'b0, 32'hF0F0_F0F0},  // OR partial mask
    '{4'd5, 6'd8,  6'd3,  6'd1,  1'b0, 32'hFFFF_FFFF},  // SHL
    '{4'd7, 6'd1,  6'd0,  6'd0,  1'b1, 32'hFFFF_FFFF},  // TID  r1 group 1
    '{4'd6, 6'd12, 6'd63, 6'd63, 1'b1, 32'hFFFF_FFFF},  // MOVI r12 = 4095
    '{4'd1, 6'd13, 6'd12, 6'd1,  1'b1, 32'h1234_5678}   // SUB partial mask
  };

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  start_i;
  logic [3:0]            op_i;
  logic [5:0]            dst_i, src_a_i, src_b_i;
  logic [0:0]            grp_i;
  logic [THREADS-1:0]    mask_i;
  logic [LANES-1:0]      lane_en_o;
  logic [0:0]            pass_o;
  logic [AW-1:0]         rd_addr_a_o, rd_addr_b_o, wr_addr_o;
  logic [LANES*XLEN-1:0] wb_data_o;
  logic                  done_o;

  int errors = 0;
  int checks = 0;
  logic [XLEN-1:0] mdl [NGROUPS][THREADS][NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_seq u_warp_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .dst_i(dst_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .grp_i(grp_i), .mask_i(mask_i),
    .lane_en_o(lane_en_o), .pass_o(pass_o), .rd_addr_a_o(rd_addr_a_o),
    .rd_addr_b_o(rd_addr_b_o), .wr_addr_o(wr_addr_o), .wb_data_o(wb_data_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] ref_alu(input logic [3:0] op,
      input logic [XLEN-1:0] a, b, input logic [11:0] imm, input int tid);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return a << b[4:0];
      4'd6: return {20'd0, imm};
      4'd7: return XLEN'(tid);
      default: return '0;
    endcase
  endfunction

  task automatic drive(input vec_t v);
    op_i = v.op; dst_i = v.dst; src_a_i = v.sa; src_b_i = v.sb;
    grp_i = v.grp; mask_i = v.mask; start_i = 1'b1;
  endtask

  // Called 1 time unit after a falling edge, in an idle or done cycle.
  // Returns 1 time unit after the falling edge inside the done cycle.
  task automatic run_vec(input vec_t v, input string dtag, input string ptag);
    logic [LANES-1:0]      exp_en;
    logic [LANES*XLEN-1:0] exp_wb, m;
    int g;
    drive(v);
    @(negedge clk); #1;
    start_i = 1'b0;
    g = int'(v.grp);
    for (int p = 0; p < PASSES; p++) begin
      exp_en = v.op[3] ? '0 : v.mask[p*LANES +: LANES];
      chk(lane_en_o == exp_en, "R3 lane enables", 512'(lane_en_o), 512'(exp_en));
      chk(pass_o == 1'(p), (p == 0) ? ptag : "R2 pass index", 512'(pass_o), 512'(p));
      chk(rd_addr_a_o == AW'((g*PASSES + p)*NREGS + int'(v.sa)), "R4 src a address",
          512'(rd_addr_a_o), 512'((g*PASSES + p)*NREGS + int'(v.sa)));
      chk(rd_addr_b_o == AW'((g*PASSES + p)*NREGS + int'(v.sb)), "R4 src b address",
          512'(rd_addr_b_o), 512'((g*PASSES + p)*NREGS + int'(v.sb)));
      chk(wr_addr_o == AW'((g*PASSES + p)*NREGS + int'(v.dst)), "R4 dst address",
          512'(wr_addr_o), 512'((g*PASSES + p)*NREGS + int'(v.dst)));
      chk(done_o == 1'b0, "R2 done low in pass", 512'(done_o), 512'(0));
      exp_wb = '0; m = '0;
      for (int l = 0; l < LANES; l++) begin
        int t;
        t = p*LANES + l;
        exp_wb[l*XLEN +: XLEN] = ref_alu(v.op, mdl[g][t][v.sa], mdl[g][t][v.sb],
                                         {v.sa, v.sb}, g*THREADS + t);
        if (exp_en[l]) m[l*XLEN +: XLEN] = '1;
      end
      chk((wb_data_o & m) == (exp_wb & m), dtag, 512'(wb_data_o & m), 512'(exp_wb & m));
      for (int l = 0; l < LANES; l++)
        if (exp_en[l]) mdl[g][p*LANES + l][v.dst] = exp_wb[l*XLEN +: XLEN];
      @(negedge clk); #1;
    end
    chk(done_o == 1'b1 && lane_en_o == '0, "R2 done pulse", 512'({done_o, lane_en_o}),
        512'({1'b1, 16'h0}));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int g = 0; g < NGROUPS; g++)
      for (int t = 0; t < THREADS; t++)
        for (int r = 0; r < NREGS; r++) mdl[g][t][r] = '0;
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; dst_i = '0; src_a_i = '0;
    src_b_i = '0; grp_i = '0; mask_i = '0;
    repeat (2) @(negedge clk);
    #1;
    chk(lane_en_o == '0 && done_o == 1'b0 && pass_o == 1'b0, "R1 reset state",
        512'({lane_en_o, done_o, pass_o}), 512'(0));
    @(negedge clk); rst_n = 1'b1; #1;
    @(negedge clk); #1;
    chk(lane_en_o == '0 && done_o == 1'b0, "R1 idle after release",
        512'({lane_en_o, done_o}), 512'(0));

    // Table walk: R5/R6 data; odd entries follow an idle gap, even ones run back to back (R8)
    for (int i = 0; i < NVEC; i++) begin
      string dtag, ptag;
      dtag = (VECS[i].op >= 4'd6) ? "R6 immediate/thread result" : "R5 lane result";
      ptag = (i > 0 && (i % 2) == 0) ? "R8 back-to-back pass 0" : "R2 pass index";
      run_vec(VECS[i], dtag, ptag);
      if (i % 2 == 0) begin
        @(negedge clk); #1;
        chk(done_o == 1'b0 && lane_en_o == '0, "R2 single done", 512'({done_o, lane_en_o}),
            512'(0));
      end
    end

    // R10: masked threads keep old value
    @(negedge clk); #1;
    run_vec('{4'd6, 6'd3, 6'd0, 6'd7, 1'b1, 32'hFFFF_FFFF}, "R6 immediate", "R2 pass index");
    run_vec('{4'd0, 6'd3, 6'd1, 6'd1, 1'b1, 32'hA5A5_0F0F}, "R5 add masked", "R8 back-to-back");
    run_vec('{4'd3, 6'd9, 6'd3, 6'd3, 1'b1, 32'hFFFF_FFFF}, "R10 masked threads kept",
            "R8 back-to-back");
    // R11: group 0 r3 untouched by group 1 writes
    run_vec('{4'd3, 6'd9, 6'd3, 6'd3, 1'b0, 32'hFFFF_FFFF}, "R11 group isolation",
            "R8 back-to-back");
    // R9: reserved opcode writes nothing, still completes
    run_vec('{4'd9, 6'd3, 6'd1, 6'd2, 1'b0, 32'hFFFF_FFFF}, "R9 reserved result",
            "R9 reserved pass");
    run_vec('{4'd3, 6'd10, 6'd3, 6'd3, 1'b0, 32'hFFFF_FFFF}, "R9 register unchanged",
            "R8 back-to-back");
    // R10: all-zero mask
    run_vec('{4'd0, 6'd1, 6'd2, 6'd2, 1'b0, 32'h0000_0000}, "R10 zero mask",
            "R2 pass index");
    run_vec('{4'd3, 6'd11, 6'd1, 6'd1, 1'b0, 32'hFFFF_FFFF}, "R10 zero mask readback",
            "R8 back-to-back");

    // R7: start while busy is ignored
    @(negedge clk); #1;
    drive('{4'd6, 6'd20, 6'd1, 6'd1, 1'b0, 32'hFFFF_FFFF});
    @(negedge clk); #1;
    drive('{4'd6, 6'd2, 6'd0, 6'd0, 1'b0, 32'hFFFF_FFFF});
    chk(wr_addr_o == AW'(20), "R7 pass 0 dst", 512'(wr_addr_o), 512'(20));
    @(negedge clk); #1;
    chk(wr_addr_o == AW'(NREGS + 20) && pass_o == 1'b1, "R7 running instruction kept",
        512'({pass_o, wr_addr_o}), 512'({1'b1, 8'(NREGS + 20)}));
    @(negedge clk); #1;
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7 single done", 512'(done_o), 512'(1));
    @(negedge clk); #1;
    chk(done_o == 1'b0 && lane_en_o == '0, "R7 intruder not started",
        512'({done_o, lane_en_o}), 512'(0));
    for (int t = 0; t < THREADS; t++) mdl[0][t][20] = 32'd65;
    run_vec('{4'd3, 6'd21, 6'd2, 6'd2, 1'b0, 32'hFFFF_FFFF}, "R7 r2 unchanged",
            "R2 pass index");

    // R1: reset mid-instruction
    @(negedge clk); #1;
    drive('{4'd6, 6'd30, 6'd1, 6'd1, 1'b0, 32'hFFFF_FFFF});
    @(negedge clk); #1;
    start_i = 1'b0;
    rst_n = 1'b0; #1;
    chk(lane_en_o == '0 && done_o == 1'b0 && pass_o == 1'b0, "R1 reset aborts",
        512'({lane_en_o, done_o, pass_o}), 512'(0));
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(done_o == 1'b0 && lane_en_o == '0, "R1 no done after abort",
          512'({done_o, lane_en_o}), 512'(0));
    end
    run_vec('{4'd3, 6'd22, 6'd3, 6'd3, 1'b0, 32'hFFFF_FFFF}, "R11 data after reset",
            "R2 pass index");
    finish_run();
  end

endmodule